// File: doc/BRIEF.md
# Segment Descriptor Base and Limit Decoder

This block turns a segment selector into the base address, byte-granular limit and, for code-segment queries, the default address and operand sizes that a segmented address path needs. A request carries a 16-bit selector, a small segment code, a flag that marks the query as a code-segment query, and the current execution mode (64-bit mode or virtual-8086 mode; neither set means protected mode). The FS and GS base values and the descriptor table size are supplied as inputs.

When a descriptor is needed, the block issues a single read on a simple table port. The table returns the 64-bit descriptor one cycle later, and the block then decodes it. Virtual-8086 queries, 64-bit data queries and every request that fails a selector check finish without a table access. Each result is announced by a one-cycle `done` pulse. The outputs stay valid until the next result is loaded. While a request is in flight, the block ignores new requests.

Segment codes on `req_seg`: 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS, 5 = GS.

Top module: `seg_desc_decoder`

## Requirements
- R1: In virtual-8086 mode (`mode_v86`=1, which takes priority over `mode_long`), the base is the selector shifted left by 4 and zero-extended, the limit is all ones, and `err`=0. No table read is issued, and `done` rises one cycle after the request is accepted.
- R2: In virtual-8086 mode, a code-segment query (`req_code`=1) returns an address size of 2 and an operand size of 2. A data query returns 0 for both sizes.
- R3: In 64-bit mode, a data query (`req_code`=0) returns `fs_base` for segment code 4, `gs_base` for segment code 5 and zero for any other code. The limit is all ones and the sizes are 0. No table read is issued, and `done` rises one cycle after acceptance.
- R4: In protected mode, a selector whose bits [15:2] are all zero is null and gives `err`=1 without a table read, with `done` one cycle after acceptance.
- R5: The descriptor's byte offset is the selector with bits [2:0] cleared. For any query that needs a descriptor, an offset greater than `tbl_limit` gives `err`=1 without a table read. An offset equal to `tbl_limit` is accepted.
- R6: A descriptor read asserts `tbl_rd_en` for exactly one cycle, in the cycle the request is accepted, with `tbl_rd_addr` equal to the offset. The table answers on `tbl_rd_data` one cycle later, and `done` rises two cycles after acceptance.
- R7: For a fetched descriptor, the 32-bit base is descriptor bits [63:56] above bits [39:16], zero-extended. In 64-bit mode the base is forced to zero instead.
- R8: The 20-bit raw limit is descriptor bits [51:48] above bits [15:0]. When the granularity bit (bit 55) is set, the raw limit is shifted left by 12 and 0xFFF is added. In 64-bit mode the limit is all ones instead.
- R9: A code-segment query whose descriptor has type bit 43 clear gives `err`=1.
- R10: For a code-segment query, the pair {L = bit 53, D = bit 54} selects the sizes: 00 gives 2/2, 01 gives 4/4, 10 gives an address size of 8 and an operand size of 4, and 11 gives `err`=1. A data query returns 0 for both sizes. In 64-bit mode a code query also fetches the descriptor.
- R11: `done` is a single-cycle pulse. The outputs hold their values until the next `done`. A request presented while a query is in flight is ignored.
- R12: Whenever `err`=1, the base, the limit and both sizes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a query (accepted when idle) |
| req_code | input | 1 | Query is a code-segment query |
| req_sel | input | 16 | Segment selector |
| req_seg | input | 3 | Segment code (4 = FS, 5 = GS) |
| mode_long | input | 1 | 64-bit mode |
| mode_v86 | input | 1 | Virtual-8086 mode |
| fs_base | input | BASE_W | FS base used in 64-bit mode |
| gs_base | input | BASE_W | GS base used in 64-bit mode |
| tbl_limit | input | 16 | Largest valid descriptor byte offset |
| tbl_rd_en | output | 1 | Descriptor table read strobe |
| tbl_rd_addr | output | 16 | Descriptor byte offset |
| tbl_rd_data | input | 64 | Descriptor, valid the cycle after the strobe |
| done | output | 1 | Result valid pulse |
| seg_base | output | BASE_W | Segment base |
| seg_limit | output | LIM_W | Byte-granular segment limit |
| addr_size | output | SZ_W | Default address size in bytes |
| opnd_size | output | SZ_W | Default operand size in bytes |
| err | output | 1 | Query failed |

## Verification
A request is driven on a falling edge and accepted at the next rising edge. Results that need no table access raise `done` at the falling edge that follows. Fetched results raise it one falling edge later, because the table read and the decode register each add one edge. The bench samples the read strobe and address just after driving a request. It then counts falling edges until `done` and compares that count with the expected latency of 1 or 2 before comparing any data. One falling edge later it confirms that `done` has dropped while the outputs still hold.

// File: rtl/seg_desc_decoder.sv
module seg_desc_decoder #(
  parameter int BASE_W = 64,
  parameter int LIM_W  = 32,
  parameter int SZ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_code,
  input  logic [15:0]       req_sel,
  input  logic [2:0]        req_seg,
  input  logic              mode_long,
  input  logic              mode_v86,
  input  logic [BASE_W-1:0] fs_base,
  input  logic [BASE_W-1:0] gs_base,
  input  logic [15:0]       tbl_limit,
  output logic              tbl_rd_en,
  output logic [15:0]       tbl_rd_addr,
  input  logic [63:0]       tbl_rd_data,
  output logic              done,
  output logic [BASE_W-1:0] seg_base,
  output logic [LIM_W-1:0]  seg_limit,
  output logic [SZ_W-1:0]   addr_size,
  output logic [SZ_W-1:0]   opnd_size,
  output logic              err
);

  localparam logic [2:0] SEG_FS = 3'd4;
  localparam logic [2:0] SEG_GS = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} state_t;
  state_t state;

  logic st_idle;
  logic q_code, q_long;
  assign st_idle = (state == S_IDLE);

  // request classification
  logic prot, need_desc, null_sel, over_lim, go_fetch, chk_err;
  logic [15:0] offs;
  assign prot      = !mode_v86 && !mode_long;
  assign need_desc = !mode_v86 && (req_code || !mode_long);
  assign null_sel  = prot && (req_sel[15:2] == 14'd0);
  assign offs      = {req_sel[15:3], 3'b000};
  assign over_lim  = need_desc && (offs > tbl_limit);
  assign chk_err   = null_sel || over_lim;
  assign go_fetch  = need_desc && !chk_err;

  assign tbl_rd_en   = st_idle && req_valid && go_fetch;
  assign tbl_rd_addr = offs;

  // results that need no descriptor
  logic [BASE_W-1:0] dir_base;
  logic [LIM_W-1:0]  dir_lim;
  logic [SZ_W-1:0]   dir_sz;
  always_comb begin
    dir_base = '0;
    dir_lim  = '1;
    dir_sz   = '0;
    if (chk_err) begin
      dir_lim = '0;
    end else if (mode_v86) begin
      dir_base = BASE_W'({req_sel, 4'h0});
      if (req_code) dir_sz = SZ_W'(2);
    end else if (req_seg == SEG_FS) begin
      dir_base = fs_base;
    end else if (req_seg == SEG_GS) begin
      dir_base = gs_base;
    end
  end

  // descriptor decode
  logic [31:0] d_base;
  logic [19:0] d_lim;
  logic [1:0]  d_ld;
  logic        d_err;
  logic [SZ_W-1:0] d_asz, d_osz;
  logic [LIM_W-1:0] d_lim_b;
  logic unused_desc;
  assign d_base  = {tbl_rd_data[63:56], tbl_rd_data[39:16]};
  assign d_lim   = {tbl_rd_data[51:48], tbl_rd_data[15:0]};
  assign d_lim_b = tbl_rd_data[55] ? LIM_W'({d_lim, 12'hFFF}) : LIM_W'(d_lim);
  assign d_ld    = {tbl_rd_data[53], tbl_rd_data[54]};
  assign d_err   = q_code && (!tbl_rd_data[43] || d_ld == 2'b11);
  assign d_asz   = !q_code ? '0 : (d_ld == 2'b00) ? SZ_W'(2) :
                   (d_ld == 2'b01) ? SZ_W'(4) : SZ_W'(8);
  assign d_osz   = !q_code ? '0 : (d_ld == 2'b00) ? SZ_W'(2) : SZ_W'(4);
  assign unused_desc = ^{tbl_rd_data[52], tbl_rd_data[47:44], tbl_rd_data[42:40]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      q_code    <= 1'b0;
      q_long    <= 1'b0;
      seg_base  <= '0;
      seg_limit <= '0;
      addr_size <= '0;
      opnd_size <= '0;
      err       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          q_code <= req_code;
          q_long <= mode_long;
          if (go_fetch) begin
            state <= S_FETCH;
          end else begin
            seg_base  <= dir_base;
            seg_limit <= dir_lim;
            addr_size <= dir_sz;
            opnd_size <= dir_sz;
            err       <= chk_err;
            state     <= S_DONE;
          end
        end
        S_FETCH: begin
          err       <= d_err;
          seg_base  <= (d_err || q_long) ? '0 : BASE_W'(d_base);
          seg_limit <= d_err ? '0 : (q_long ? '1 : d_lim_b);
          addr_size <= d_err ? '0 : d_asz;
          opnd_size <= d_err ? '0 : d_osz;
          state     <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done = (state == S_DONE);

endmodule

// File: rtl/seg_desc_decoder_chk.sv
module seg_desc_decoder_chk #(
  parameter int BASE_W = 64,
  parameter int LIM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_code,
  input logic [15:0]       req_sel,
  input logic              mode_long,
  input logic              mode_v86,
  input logic [15:0]       tbl_limit,
  input logic              tbl_rd_en,
  input logic              done,
  input logic              err,
  input logic [BASE_W-1:0] seg_base,
  input logic [LIM_W-1:0]  seg_limit,
  input logic              st_idle
);

  AST_V86_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_valid && mode_v86) |=> (done && !err && seg_base == BASE_W'({$past(req_sel), 4'h0}) && seg_limit == '1)); // R1

  AST_V86_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_v86) |-> !tbl_rd_en); // R1

  AST_NULL_SEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_valid && !mode_v86 && !mode_long && req_sel[15:2] == 14'd0) |=> (done && err)); // R4

  AST_OVER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_valid && !mode_v86 && (req_code || !mode_long) && ({req_sel[15:3], 3'b000} > tbl_limit)) |=> (done && err)); // R5

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> (!done && !tbl_rd_en) ##1 done); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && $stable(seg_base) && $stable(seg_limit) && $stable(err))); // R11

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (seg_base == '0 && seg_limit == '0)); // R12

endmodule

bind seg_desc_decoder seg_desc_decoder_chk #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_chk (.*);

// File: tb/seg_desc_decoder_bench.sv
module seg_desc_decoder_bench;
  localparam int BASE_W = 64;
  localparam int LIM_W  = 32;
  localparam int SZ_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_code = 1'b0, mode_long = 1'b0, mode_v86 = 1'b0;
  logic [15:0] req_sel = '0, tbl_limit = 16'h0060;
  logic [2:0] req_seg = '0;
  logic [BASE_W-1:0] fs_base = 64'hFFFF_8000_1234_5000;
  logic [BASE_W-1:0] gs_base = 64'h0000_7FFF_ABCD_E000;
  logic tbl_rd_en, done, err;
  logic [15:0] tbl_rd_addr;
  logic [63:0] tbl_rd_data;
  logic [BASE_W-1:0] seg_base;
  logic [LIM_W-1:0] seg_limit;
  logic [SZ_W-1:0] addr_size, opnd_size;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  seg_desc_decoder #(.BASE_W(BASE_W), .LIM_W(LIM_W), .SZ_W(SZ_W)) u_seg_desc_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_sel(req_sel), .req_seg(req_seg), .mode_long(mode_long), .mode_v86(mode_v86),
    .fs_base(fs_base), .gs_base(gs_base), .tbl_limit(tbl_limit),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
    .done(done), .seg_base(seg_base), .seg_limit(seg_limit),
    .addr_size(addr_size), .opnd_size(opnd_size), .err(err));

  // descriptor table model: 16 entries, one-cycle registered read
  function automatic logic [31:0] e_base(int i);
    return 32'h0135_79BD * i + (i << 28);
  endfunction
  function automatic logic [19:0] e_lim(int i);
    return 20'(20'h0_1234 * i + i);
  endfunction
  function automatic logic [3:0] e_type(int i);
    return {~i[3], i[2:0]};
  endfunction
  function automatic logic [63:0] e_desc(int i);
    logic [31:0] b = e_base(i);
    logic [19:0] l = e_lim(i);
    return {b[31:24], i[0], i[1], i[2], 1'b0, l[19:16], 4'b1001, e_type(i), b[23:0], l[15:0]};
  endfunction

  logic [63:0] tbl_q = '0;
  always @(posedge clk) if (tbl_rd_en) tbl_q <= e_desc(int'(tbl_rd_addr[6:3]));
  assign tbl_rd_data = tbl_q;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] sel, input logic [2:0] seg, input bit code,
                     input bit lng, input bit v86, input bit exp_rd,
                     input logic [63:0] eb, input logic [31:0] el,
                     input logic [3:0] ea, input logic [3:0] eo, input bit ee,
                     input string tag);
    int lat;
    @(negedge clk);
    req_sel = sel; req_seg = seg; req_code = code; mode_long = lng; mode_v86 = v86;
    req_valid = 1'b1;
    #1;
    check(tbl_rd_en == exp_rd, {tag, " R6 read strobe"}, 64'(tbl_rd_en), 64'(exp_rd));
    if (exp_rd)
      check(tbl_rd_addr == {sel[15:3], 3'b000}, {tag, " R5 read offset"}, 64'(tbl_rd_addr), 64'({sel[15:3], 3'b000}));
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == (exp_rd ? 2 : 1), {tag, " R6 latency"}, 64'(lat), 64'(exp_rd ? 2 : 1));
    check(err == ee, {tag, " err"}, 64'(err), 64'(ee));
    check(seg_base == eb, {tag, " base"}, seg_base, eb);
    check(seg_limit == el, {tag, " limit"}, 64'(seg_limit), 64'(el));
    check(addr_size == ea && opnd_size == eo, {tag, " sizes"}, 64'({addr_size, opnd_size}), 64'({ea, eo}));
    @(negedge clk);
    check(!done && seg_base == eb, {tag, " R11 pulse/hold"}, 64'(done), 64'(0));
  endtask

  // expected result for a descriptor-backed query on entry idx
  task automatic run_desc(input int idx, input bit ti, input logic [1:0] rpl,
                          input bit code, input bit lng);
    logic [15:0] sel = {13'(idx), ti, rpl};
    bit nul = !lng && sel[15:2] == 0;
    bit need = code || !lng;
    bit over = need && !nul && ({sel[15:3], 3'b000} > tbl_limit);
    logic [1:0] ld = {idx[2], idx[1]};
    bit derr = code && (e_type(idx)[3] == 1'b0 || ld == 2'b11);
    logic [63:0] eb; logic [31:0] el; logic [3:0] ea, eo; bit ee;
    if (!need) begin
      run(sel, 3'd3, 0, lng, 0, 0, 64'd0, '1, 0, 0, 0, "R3 long DS");
    end else if (nul || over) begin
      run(sel, 3'd3, code, lng, 0, 0, 64'd0, 32'd0, 0, 0, 1, nul ? "R4 null" : "R5 over limit R12");
    end else begin
      ee = derr;
      eb = (ee || lng) ? 64'd0 : 64'(e_base(idx));
      el = ee ? 32'd0 : lng ? '1 : idx[0] ? {e_lim(idx), 12'hFFF} : 32'(e_lim(idx));
      ea = (ee || !code) ? 4'd0 : (ld == 0) ? 4'd2 : (ld == 1) ? 4'd4 : 4'd8;
      eo = (ee || !code) ? 4'd0 : (ld == 0) ? 4'd2 : 4'd4;
      run(sel, 3'd1, code, lng, 0, 1, eb, el, ea, eo, ee,
          code ? (derr ? "R9 R10 R12 code err" : "R10 code sizes R7 R8") : "R7 R8 data");
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err && !tbl_rd_en && seg_base == 0, "reset state", 64'(done), 64'(0));

    // R1 R2: virtual-8086 sweep
    for (int s = 0; s < 65536; s += 4099) begin
      for (int c = 0; c < 2; c++) begin
        run(16'(s), 3'(s % 6), c[0], s[0], 1, 0, 64'({16'(s), 4'h0}), '1,
            c[0] ? 4'd2 : 4'd0, c[0] ? 4'd2 : 4'd0, 0, c[0] ? "R1 R2 v86 code" : "R1 v86");
      end
    end

    // R3: 64-bit data queries on every segment code
    for (int g = 0; g < 8; g++) begin
      run(16'h0000, 3'(g), 0, 1, 0, 0,
          (g == 4) ? fs_base : (g == 5) ? gs_base : 64'd0, '1, 0, 0, 0, "R3 long base");
    end

    // R4 R5 R7 R8 R9 R10 R12: descriptor sweep, both modes, both query kinds
    for (int pass = 0; pass < 2; pass++) begin
      tbl_limit = pass == 0 ? 16'h0060 : 16'h005F;
      for (int i = 0; i < 16; i++)
        for (int t = 0; t < 2; t++)
          for (int r = 0; r < 4; r += 3)
            for (int c = 0; c < 2; c++)
              for (int m = 0; m < 2; m++)
                run_desc(i, t[0], 2'(r), c[0], m[0]);
    end

    // R11: a request during a fetch is ignored
    tbl_limit = 16'h0078;
    @(negedge clk);
    req_sel = 16'h0018; req_code = 0; mode_long = 0; mode_v86 = 0; req_valid = 1'b1;
    @(negedge clk);
    req_sel = 16'h0028; req_valid = 1'b1;
    #1;
    check(!tbl_rd_en, "R11 busy no second read", 64'(tbl_rd_en), 64'(0));
    @(negedge clk);
    check(done && seg_base == 64'(e_base(3)), "R11 first result kept", seg_base, 64'(e_base(3)));
    req_valid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(!done && seg_base == 64'(e_base(3)), "R11 ignored request no done", 64'(done), 64'(0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule